// File: doc/BRIEF.md
# Serial Memory Slave with Execute-in-Place

This block is the single-lane serial front end of a small byte-addressed memory. An external host selects it with an active-low chip select, clocks it with a serial clock and shifts commands in on one data line; the block answers read commands on a separate output line and drives that line only while it is returning read data. All three serial inputs are brought into the system clock domain and their edges are detected there, so the memory array and all control state run on one synchronous clock.

A transaction is an opcode byte, three address bytes, an optional mode byte and then any number of data bytes. Three opcodes are recognised: a plain read that has no mode byte, a read with a mode byte, and a write with a mode byte. A suitable mode byte arms a sticky execute-in-place state. When that state is in force, the next selection skips the opcode entirely and starts with the address, repeating whichever operation was last decoded. The host must arm the state again in every transaction to keep it.

The array is a small synchronous RAM indexed by the low address bits. The address advances after every data byte and wraps from the top of the array back to zero.

Top module: `spi_xip_slave`

## Requirements
- R1: Serial clock polarity 0 and polarity 1 with phase matching (modes 0 and 3) both work; input bits are captured on the rising serial clock edge, the output bit changes only after a falling edge, and every field travels most significant bit first.
- R2: With execute-in-place inactive, the first byte after chip select falls is decoded as an opcode: 0x03 is a plain read whose data follows the third address byte with no mode byte.
- R3: The address is 24 bits; only its low ARR_AW bits (6 by default, a 64-byte array) select a byte, so addresses differing only in higher bits reach the same byte.
- R4: Opcode 0x0B is a read with a mode byte after the address; a mode byte whose upper four bits equal 0xA (lower four bits any value) arms execute-in-place.
- R5: Opcode 0x02 is a write with a mode byte after the address; only the exact mode value 0xA5 arms execute-in-place, and a value such as 0xA3 does not.
- R6: When execute-in-place was armed in the previous transaction, the next transaction begins with the address phase and repeats the previously decoded operation, including its mode byte.
- R7: Any mode byte that does not arm, and any transaction ended before its mode byte completes, leaves execute-in-place inactive from the next selection on, so that selection begins with an opcode.
- R8: An unrecognised opcode makes the block ignore the rest of the transaction: the output enable stays low and no byte of the array changes.
- R9: The output enable is high only during the data phase of a read, from the first falling serial clock edge of that phase, and is low again once chip select has risen.
- R10: Read and write data bytes go to consecutive addresses, and the address wraps from the top of the array to zero.
- R11: Chip select rising at any bit position aborts the transaction and clears the bit counter; the next transaction is decoded from its first bit.
- R12: After reset, execute-in-place is inactive and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; serial inputs are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| spi_miso_oe | output | 1 | High while spi_miso is driven; low means high impedance |

## Verification
The capture of the last mode-byte bit and the deassertion of chip select can land in the same system clock cycle, and the arm decision must still be committed at that deselection. The bench provokes this by raising the serial clock and chip select at the same instant at the end of a mode byte carrying 0xAF, so both edges pass the synchronisers together. It then judges the outcome by sending an address without an opcode: the expected byte returns only if the arm was kept, and a following plain read with an opcode shows that the state was then dropped by a non-arming mode byte.

// File: rtl/spi_xip_pkg.sv
package spi_xip_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPC,
    PH_ADDR,
    PH_MODE,
    PH_DATA,
    PH_IGN
  } phase_e;

  typedef enum logic [1:0] {
    OP_RD,
    OP_XRD,
    OP_XWR
  } op_e;

endpackage

// File: rtl/spi_xip_sync.sv
module spi_xip_sync #(
  parameter int         STAGES  = 2,
  parameter logic [2:0] RST_VAL = 3'b100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_in,
  input  logic sck_in,
  input  logic mosi_in,
  output logic cs_n_s,
  output logic mosi_s,
  output logic cs_rise,
  output logic cs_fall,
  output logic sck_rise,
  output logic sck_fall
);

  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0][2:0] pipe_q;
  logic [DEPTH-1:0][2:0] pipe_d;
  logic [2:0]            cur;
  logic [2:0]            prev;

  assign pipe_d = {pipe_q[DEPTH-2:0], {cs_n_in, sck_in, mosi_in}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {DEPTH{RST_VAL}};
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign cur  = pipe_q[STAGES-1];
  assign prev = pipe_q[STAGES];

  assign cs_n_s   = cur[2];
  assign mosi_s   = cur[0];
  assign cs_rise  =  cur[2] & ~prev[2];
  assign cs_fall  = ~cur[2] &  prev[2];
  assign sck_rise =  cur[1] & ~prev[1];
  assign sck_fall = ~cur[1] &  prev[1];

endmodule

// File: rtl/spi_xip_ram.sv
module spi_xip_ram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    if (re) begin
      rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/spi_xip_ctrl.sv
module spi_xip_ctrl
  import spi_xip_pkg::*;
#(
  parameter int         AW      = 6,
  parameter logic [7:0] OPC_RD  = 8'h03,
  parameter logic [7:0] OPC_XRD = 8'h0B,
  parameter logic [7:0] OPC_XWR = 8'h02
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi,
  input  logic [7:0]    ram_rdata,
  output logic          ram_we,
  output logic          ram_re,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic          miso,
  output logic          miso_oe,
  output phase_e        phase_o,
  output logic          xip_o
);

  localparam logic [3:0] XIP_NIBBLE = 4'hA;
  localparam logic [7:0] XIP_EXACT  = 8'hA5;
  localparam int         ADDR_BYTES = 3;

  phase_e        phase_q, phase_d;
  op_e           op_q, op_d;
  logic [2:0]    bitcnt_q, bitcnt_d;
  logic [1:0]    bytecnt_q, bytecnt_d;
  logic [6:0]    shreg_q, shreg_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          xip_q, xip_d;
  logic          arm_q, arm_d;
  logic          miso_q, miso_d;
  logic          oe_q, oe_d;

  logic [7:0]    byte_in;
  logic [AW+7:0] addr_cat;
  logic [AW-1:0] addr_shift;
  logic          shifting;
  logic          byte_done;

  assign byte_in    = {shreg_q, mosi};
  assign addr_cat   = {addr_q, byte_in};
  assign addr_shift = addr_cat[AW-1:0];
  assign shifting   = sck_rise && (phase_q != PH_IDLE) && (phase_q != PH_IGN);
  assign byte_done  = shifting && (bitcnt_q == 3'd7);

  always_comb begin
    phase_d   = phase_q;
    op_d      = op_q;
    bitcnt_d  = bitcnt_q;
    bytecnt_d = bytecnt_q;
    shreg_d   = shreg_q;
    addr_d    = addr_q;
    xip_d     = xip_q;
    arm_d     = arm_q;
    miso_d    = miso_q;
    oe_d      = oe_q;
    ram_we    = 1'b0;
    ram_re    = 1'b0;
    ram_addr  = addr_q;
    ram_wdata = byte_in;

    if (cs_fall) begin
      phase_d   = xip_q ? PH_ADDR : PH_OPC;
      bitcnt_d  = 3'd0;
      bytecnt_d = 2'd0;
      arm_d     = 1'b0;
    end else if (shifting) begin
      shreg_d  = byte_in[6:0];
      bitcnt_d = bitcnt_q + 3'd1;
      if (byte_done) begin
        unique case (phase_q)
          PH_OPC: begin
            bytecnt_d = 2'd0;
            if (byte_in == OPC_RD) begin
              op_d    = OP_RD;
              phase_d = PH_ADDR;
            end else if (byte_in == OPC_XRD) begin
              op_d    = OP_XRD;
              phase_d = PH_ADDR;
            end else if (byte_in == OPC_XWR) begin
              op_d    = OP_XWR;
              phase_d = PH_ADDR;
            end else begin
              phase_d = PH_IGN;
            end
          end
          PH_ADDR: begin
            addr_d    = addr_shift;
            bytecnt_d = bytecnt_q + 2'd1;
            if (bytecnt_q == 2'(ADDR_BYTES - 1)) begin
              if (op_q == OP_RD) begin
                phase_d  = PH_DATA;
                ram_re   = 1'b1;
                ram_addr = addr_shift;
                addr_d   = addr_shift + 1'b1;
              end else begin
                phase_d = PH_MODE;
              end
            end
          end
          PH_MODE: begin
            arm_d   = (op_q == OP_XWR) ? (byte_in == XIP_EXACT)
                                       : (byte_in[7:4] == XIP_NIBBLE);
            phase_d = PH_DATA;
            if (op_q != OP_XWR) begin
              ram_re = 1'b1;
              addr_d = addr_q + 1'b1;
            end
          end
          PH_DATA: begin
            if (op_q == OP_XWR) begin
              ram_we = 1'b1;
            end else begin
              ram_re = 1'b1;
            end
            addr_d = addr_q + 1'b1;
          end
          default: ;
        endcase
      end
    end

    if (sck_fall && (phase_q == PH_DATA) && (op_q != OP_XWR)) begin
      miso_d = ram_rdata[3'd7 - bitcnt_q];
      oe_d   = 1'b1;
    end

    if (cs_rise) begin
      phase_d  = PH_IDLE;
      bitcnt_d = 3'd0;
      xip_d    = arm_d;
      oe_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      op_q      <= OP_RD;
      bitcnt_q  <= 3'd0;
      bytecnt_q <= 2'd0;
      shreg_q   <= 7'd0;
      addr_q    <= '0;
      xip_q     <= 1'b0;
      arm_q     <= 1'b0;
      miso_q    <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      op_q      <= op_d;
      bitcnt_q  <= bitcnt_d;
      bytecnt_q <= bytecnt_d;
      shreg_q   <= shreg_d;
      addr_q    <= addr_d;
      xip_q     <= xip_d;
      arm_q     <= arm_d;
      miso_q    <= miso_d;
      oe_q      <= oe_d;
    end
  end

  assign miso    = miso_q;
  assign miso_oe = oe_q;
  assign phase_o = phase_q;
  assign xip_o   = xip_q;

endmodule

// File: rtl/spi_xip_slave.sv
module spi_xip_slave #(
  parameter int         ARR_AW      = 6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] OPC_RD      = 8'h03,
  parameter logic [7:0] OPC_XRD     = 8'h0B,
  parameter logic [7:0] OPC_XWR     = 8'h02
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);

  logic [1:0]          rst_pipe;
  logic                rst_n_s;
  logic                cs_n_s;
  logic                mosi_s;
  logic                cs_rise;
  logic                cs_fall;
  logic                sck_rise;
  logic                sck_fall;
  logic                ram_we;
  logic                ram_re;
  logic [ARR_AW-1:0]   ram_addr;
  logic [7:0]          ram_wdata;
  logic [7:0]          ram_rdata;
  spi_xip_pkg::phase_e phase;
  logic                xip_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe[1];

  spi_xip_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cs_n_in  (spi_cs_n),
    .sck_in   (spi_sck),
    .mosi_in  (spi_mosi),
    .cs_n_s   (cs_n_s),
    .mosi_s   (mosi_s),
    .cs_rise  (cs_rise),
    .cs_fall  (cs_fall),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
  );

  spi_xip_ctrl #(
    .AW      (ARR_AW),
    .OPC_RD  (OPC_RD),
    .OPC_XRD (OPC_XRD),
    .OPC_XWR (OPC_XWR)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .mosi      (mosi_s),
    .ram_rdata (ram_rdata),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .miso      (spi_miso),
    .miso_oe   (spi_miso_oe),
    .phase_o   (phase),
    .xip_o     (xip_act)
  );

  spi_xip_ram #(
    .AW (ARR_AW),
    .DW (8)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .re    (ram_re),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

endmodule

// File: rtl/spi_xip_slave_chk.sv
module spi_xip_slave_chk
  import spi_xip_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   cs_n_s,
  input logic   cs_rise,
  input logic   cs_fall,
  input logic   sck_fall,
  input logic   xip,
  input phase_e phase,
  input logic   miso,
  input logic   miso_oe
);

  AST_OE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n_s) && cs_n_s) |-> !miso_oe);  // R9

  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(miso));  // R1

  AST_XIP_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(xip));  // R7

  AST_XIP_SKIPS_OPC: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && xip) |=> (phase == PH_ADDR));  // R6

  AST_OPC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !xip) |=> (phase == PH_OPC));  // R2

  AST_IGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGN) |-> !miso_oe);  // R8

endmodule

bind spi_xip_slave spi_xip_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .cs_n_s   (cs_n_s),
  .cs_rise  (cs_rise),
  .cs_fall  (cs_fall),
  .sck_fall (sck_fall),
  .xip      (xip_act),
  .phase    (phase),
  .miso     (spi_miso),
  .miso_oe  (spi_miso_oe)
);

// File: tb/spi_xip_slave_bench.sv
module spi_xip_slave_bench;

  localparam logic [7:0] OP_RD  = 8'h03;
  localparam logic [7:0] OP_XRD = 8'h0B;
  localparam logic [7:0] OP_XWR = 8'h02;
  localparam int         ARR    = 64;
  localparam int         NVEC   = 7;

  typedef struct packed {
    logic        is_wr;
    logic [7:0]  op;
    logic [23:0] addr;
    logic [7:0]  mode;
    logic [7:0]  d0;
    logic [7:0]  d1;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, OP_XWR, 24'h000010, 8'h00, 8'h11, 8'h22},
    '{1'b1, OP_XWR, 24'h00003F, 8'h5A, 8'hAA, 8'hBB},
    '{1'b0, OP_RD,  24'h000010, 8'h00, 8'h00, 8'h00},
    '{1'b0, OP_XRD, 24'h00003F, 8'h00, 8'h00, 8'h00},
    '{1'b1, OP_XWR, 24'hF80020, 8'h12, 8'h5C, 8'hC3},
    '{1'b0, OP_RD,  24'h000020, 8'h00, 8'h00, 8'h00},
    '{1'b0, OP_XRD, 24'h07FFE0, 8'h00, 8'h00, 8'h00}
  };

  logic clk;
  logic rst_n;
  logic spi_cs_n;
  logic spi_sck;
  logic spi_mosi;
  logic spi_miso;
  logic spi_miso_oe;

  int   n_chk;
  int   n_fail;
  bit   cpol;
  bit   oe_pre;
  bit   oe_any;
  int   npre;
  logic [7:0] tx_b [16];
  logic [7:0] rx_b [16];
  logic [7:0] wr_b [4];
  logic [7:0] model [ARR];

  spi_xip_slave u_spi_xip_slave (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (spi_cs_n),
    .spi_sck     (spi_sck),
    .spi_mosi    (spi_mosi),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe)
  );

  initial clk = 1'b0;
  always #4ns clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input bit skip_opc, input logic [7:0] op, input logic [23:0] addr,
                     input bit has_mode, input logic [7:0] mode, input int ndata,
                     input bit is_wr, input int cut_bits, input bit collide);
    int n;
    int nbits;
    n = 0;
    if (!skip_opc) begin tx_b[n] = op; n++; end
    tx_b[n] = addr[23:16]; n++;
    tx_b[n] = addr[15:8];  n++;
    tx_b[n] = addr[7:0];   n++;
    if (has_mode) begin tx_b[n] = mode; n++; end
    npre = n;
    for (int k = 0; k < ndata; k++) begin
      tx_b[n] = is_wr ? wr_b[k] : 8'h00;
      n++;
    end
    nbits  = (cut_bits >= 0) ? cut_bits : n * 8;
    oe_pre = 1'b0;
    oe_any = 1'b0;
    spi_sck = cpol;
    #128ns;
    spi_cs_n = 1'b0;
    #128ns;
    for (int i = 0; i < nbits; i++) begin
      spi_sck  = 1'b0;
      spi_mosi = tx_b[i / 8][7 - (i % 8)];
      #64ns;
      rx_b[i / 8][7 - (i % 8)] = spi_miso;
      if (spi_miso_oe) begin
        oe_any = 1'b1;
        if (i / 8 < npre) oe_pre = 1'b1;
      end
      if (collide && (i == nbits - 1)) begin
        spi_sck  = 1'b1;
        spi_cs_n = 1'b1;
      end else begin
        spi_sck = 1'b1;
      end
      #64ns;
    end
    if (!cpol && !collide) begin
      spi_sck = 1'b0;
      #64ns;
    end
    spi_cs_n = 1'b1;
    #64ns;
    spi_sck = cpol;
    #192ns;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk    = 0;
    n_fail   = 0;
    cpol     = 1'b0;
    rst_n    = 1'b0;
    spi_cs_n = 1'b1;
    spi_sck  = 1'b0;
    spi_mosi = 1'b0;
    #40ns;
    chk("R12 output enable low in reset", 32'(spi_miso_oe), 32'd0);
    #40ns;
    rst_n = 1'b1;
    #80ns;
    chk("R12 output enable low after reset", 32'(spi_miso_oe), 32'd0);

    // Vector table: writes update the bench model, reads compare against it (R2 R3 R10 R12)
    for (int v = 0; v < NVEC; v++) begin
      wr_b[0] = VECS[v].d0;
      wr_b[1] = VECS[v].d1;
      txn(1'b0, VECS[v].op, VECS[v].addr, VECS[v].op != OP_RD, VECS[v].mode,
          2, VECS[v].is_wr, -1, 1'b0);
      if (VECS[v].is_wr) begin
        for (int k = 0; k < 2; k++) model[(int'(VECS[v].addr[5:0]) + k) % ARR] = wr_b[k];
      end else begin
        for (int k = 0; k < 2; k++)
          chk($sformatf("R2 R3 R10 R12 vector %0d byte %0d", v, k),
              32'(rx_b[npre + k]), 32'(model[(int'(VECS[v].addr[5:0]) + k) % ARR]));
      end
    end

    // R4 R9: arming read; no output enable before data, none after deselect
    txn(1'b0, OP_XRD, 24'h000010, 1'b1, 8'hA7, 2, 1'b0, -1, 1'b0);
    chk("R4 armed read byte0", 32'(rx_b[npre]), 32'h11);
    chk("R4 armed read byte1", 32'(rx_b[npre + 1]), 32'h22);
    chk("R9 no output enable before data", 32'(oe_pre), 32'd0);
    chk("R9 output enable during data", 32'(oe_any), 32'd1);
    chk("R9 output enable low after deselect", 32'(spi_miso_oe), 32'd0);
    // R6: opcode skipped, read repeated, re-armed with 0xA0
    txn(1'b1, 8'h00, 24'h00003F, 1'b1, 8'hA0, 2, 1'b0, -1, 1'b0);
    chk("R6 skipped opcode byte0", 32'(rx_b[npre]), 32'hAA);
    chk("R6 wrap byte1", 32'(rx_b[npre + 1]), 32'hBB);
    // R7: non-arming mode clears the state
    txn(1'b1, 8'h00, 24'h000020, 1'b1, 8'h00, 1, 1'b0, -1, 1'b0);
    chk("R6 second repeat", 32'(rx_b[npre]), 32'h5C);
    txn(1'b0, OP_RD, 24'h000010, 1'b0, 8'h00, 1, 1'b0, -1, 1'b0);
    chk("R7 opcode decoded after clear", 32'(rx_b[npre]), 32'h11);

    // R5: 0xA3 does not arm a write
    wr_b[0] = 8'h01; wr_b[1] = 8'h02;
    txn(1'b0, OP_XWR, 24'h000008, 1'b1, 8'hA3, 2, 1'b1, -1, 1'b0);
    txn(1'b0, OP_RD, 24'h000008, 1'b0, 8'h00, 2, 1'b0, -1, 1'b0);
    chk("R5 partial match not armed byte0", 32'(rx_b[npre]), 32'h01);
    chk("R5 partial match not armed byte1", 32'(rx_b[npre + 1]), 32'h02);
    // R5 R6: 0xA5 arms; next cycle repeats the write without opcode
    wr_b[0] = 8'h33; wr_b[1] = 8'h44;
    txn(1'b0, OP_XWR, 24'h000008, 1'b1, 8'hA5, 2, 1'b1, -1, 1'b0);
    wr_b[0] = 8'h55; wr_b[1] = 8'h66;
    txn(1'b1, 8'h00, 24'h00000A, 1'b1, 8'h00, 2, 1'b1, -1, 1'b0);
    txn(1'b0, OP_RD, 24'h000008, 1'b0, 8'h00, 4, 1'b0, -1, 1'b0);
    chk("R5 exact match write", 32'({rx_b[npre], rx_b[npre + 1]}), 32'h3344);
    chk("R6 repeated write", 32'({rx_b[npre + 2], rx_b[npre + 3]}), 32'h5566);

    // R8: unknown opcode, trailing bytes ignored
    wr_b[0] = 8'h77; wr_b[1] = 8'h77;
    txn(1'b0, 8'h9F, 24'h000008, 1'b1, 8'h00, 2, 1'b1, -1, 1'b0);
    chk("R8 output enable stays low", 32'(oe_any), 32'd0);
    txn(1'b0, OP_RD, 24'h000008, 1'b0, 8'h00, 1, 1'b0, -1, 1'b0);
    chk("R8 array unchanged", 32'(rx_b[npre]), 32'h33);

    // R11: abort mid-address, then a fresh transaction
    txn(1'b0, OP_XRD, 24'h000000, 1'b1, 8'h00, 0, 1'b0, 19, 1'b0);
    txn(1'b0, OP_RD, 24'h000010, 1'b0, 8'h00, 1, 1'b0, -1, 1'b0);
    chk("R11 decode after abort", 32'(rx_b[npre]), 32'h11);
    // R7: abort before mode byte in an execute-in-place cycle clears it
    txn(1'b0, OP_XRD, 24'h000010, 1'b1, 8'hA0, 1, 1'b0, -1, 1'b0);
    chk("R4 arm before abort", 32'(rx_b[npre]), 32'h11);
    txn(1'b1, 8'h00, 24'h000000, 1'b1, 8'h00, 0, 1'b0, 8, 1'b0);
    txn(1'b0, OP_RD, 24'h000020, 1'b0, 8'h00, 1, 1'b0, -1, 1'b0);
    chk("R7 abort clears state", 32'(rx_b[npre]), 32'h5C);

    // R4 R7: last mode bit and deselect in the same cycle
    txn(1'b0, OP_XRD, 24'h000020, 1'b1, 8'hAF, 0, 1'b0, -1, 1'b1);
    txn(1'b1, 8'h00, 24'h000021, 1'b1, 8'h00, 1, 1'b0, -1, 1'b0);
    chk("R4 arm kept at simultaneous deselect", 32'(rx_b[npre]), 32'hC3);
    txn(1'b0, OP_RD, 24'h000010, 1'b0, 8'h00, 1, 1'b0, -1, 1'b0);
    chk("R7 cleared after collision test", 32'(rx_b[npre]), 32'h11);

    // R1: mode 3 (clock idles high)
    cpol = 1'b1;
    wr_b[0] = 8'h9E; wr_b[1] = 8'h4D;
    txn(1'b0, OP_XWR, 24'h000030, 1'b1, 8'h00, 2, 1'b1, -1, 1'b0);
    txn(1'b0, OP_RD, 24'h000030, 1'b0, 8'h00, 2, 1'b0, -1, 1'b0);
    chk("R1 mode 3 byte0", 32'(rx_b[npre]), 32'h9E);
    chk("R1 mode 3 byte1", 32'(rx_b[npre + 1]), 32'h4D);
    cpol = 1'b0;

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule